// File: doc/BRIEF.md
# Programmable Raster Timing Generator

The block produces the horizontal and vertical timing of a video raster from a set of programmed register values. A pixel counter runs across each line and a line counter runs down each frame. From the two counts the block derives the sync pulses, the blanking flags and a data-enable flag. Count zero on each axis is the first cycle of the sync pulse. After the sync pulse comes the back porch, then a leading border, the addressable pixels, a trailing border, and finally the front porch up to the programmed total.

Incoming pixels arrive on a valid/ready stream. The block raises `pix_in_ready` only in addressable cycles while the counters run, and takes a pixel when valid and ready are both high. It holds no buffer. If the source has no pixel ready for an addressable cycle, the raster does not stall: that cycle shows the blank color. The output multiplexer picks one of four values: the streamed pixel, a border color in the border bands, zero in blanking, or a forced blank color. The current position, the vertical blank flag and a frame counter can be read at the ports.

Timing values are written into a staging copy. That copy moves into the working copy only at the end of a frame, or at any time while the counters are stopped. A staging copy whose horizontal timing is too tight is flagged and never moved in.

Top module: `raster_timing_gen`

## Requirements
- R1: While running, `pos_h` steps by one every cycle and returns to 0 after reaching the programmed horizontal total. `pos_v` steps by one each time `pos_h` returns to 0, and returns to 0 after reaching the programmed vertical total. Both totals are programmed as period minus one.
- R2: The horizontal sync is asserted while `pos_h` is below the horizontal sync-end value, and the vertical sync while `pos_v` is below the vertical sync-end value. Control bit 2 (horizontal) and control bit 3 (vertical) invert the output when set, making the pulse active-low.
- R3: `hblank` is high when `pos_h` is below blank-end or at or above blank-start. `vblank` follows the same rule for `pos_v` and serves as the vertical-blank status.
- R4: `de` is high when neither axis is blanked, `pos_h` lies in [blank-end + leading border, blank-start − trailing border), and `pos_v` lies in the matching vertical interval. `pix_in_ready` equals `de` while running and is 0 while stopped.
- R5: When not forced blank, `pix_out` shows 0 during blanking, the border color in non-blank cycles outside the addressable area, `pix_in_data` in addressable cycles with `pix_in_valid` high, and the blank color in addressable cycles with `pix_in_valid` low.
- R6: While control bit 1 is set, `pix_out` shows the blank color in every cycle, and the sync, blank and enable outputs are unaffected.
- R7: Control bit 0 runs the counters. While it is clear, `pos_h`, `pos_v` and `frame_cnt` hold their values.
- R8: `frame_cnt` (FCW bits) increments by one on the clock edge at which a running line counter steps from a non-blank line into a blank line. It wraps to 0 silently.
- R9: Writes to timing registers take effect only at the edge where a running raster wraps from the last pixel of the last line. While stopped, they take effect on the next edge. Control and color writes take effect on the next edge.
- R10: `timing_bad` is high when the staged horizontal timing has a blank interval (front porch + blank-end) shorter than 56 pixels, a front porch (total + 1 − blank-start) shorter than 4, or a back porch (blank-end − sync-end) shorter than 4. Such a staged set is never moved into the working copy.
- R11: Register addresses: 0 control, 1 horizontal total, 2 vertical total, 3 horizontal sync-end, 4 vertical sync-end, 5 horizontal blank (end in bits 11:0, start in bits 27:16), 6 vertical blank (same layout), 7 horizontal borders (leading in 11:0, trailing in 27:16), 8 vertical borders (same layout), 9 blank color (23:0), 10 border color (23:0). Single-value registers use bits 11:0. Reset clears all registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register address |
| cfg_wdata | input | DW | Register write data |
| pix_in_valid | input | 1 | Incoming pixel valid |
| pix_in_ready | output | 1 | Block takes a pixel in this cycle |
| pix_in_data | input | PXW | Incoming pixel, three components |
| pix_out | output | PXW | Output pixel |
| de | output | 1 | Addressable-area enable |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| hblank | output | 1 | Horizontal blank |
| vblank | output | 1 | Vertical blank status |
| pos_h | output | CW | Current pixel count |
| pos_v | output | CW | Current line count |
| frame_cnt | output | FCW | Frame counter |
| timing_bad | output | 1 | Staged horizontal timing is rejected |

## Verification
Every output is a direct decode of the counters and the working timing copy. A wrong count or a wrongly loaded working copy therefore shows up on `pos_h`, `hblank`, `de` or `pix_out` in the very next cycle. The exception is a staging load that happens at the wrong moment. That fault stays hidden until the pixel count reaches a boundary that the new values moved, which happens within one line. A frame-counter fault shows up only at the next vertical-blank entry, so the stimulus runs more than 16 frames to reach the counter's wrap.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  parameter int CW = 12;
  parameter int MIN_HBLANK = 56;
  parameter int MIN_PORCH = 4;

  localparam int REG_CTRL    = 0;
  localparam int REG_HTOT    = 1;
  localparam int REG_VTOT    = 2;
  localparam int REG_HSYNC   = 3;
  localparam int REG_VSYNC   = 4;
  localparam int REG_HBLANK  = 5;
  localparam int REG_VBLANK  = 6;
  localparam int REG_HBORDER = 7;
  localparam int REG_VBORDER = 8;
  localparam int REG_BLANKC  = 9;
  localparam int REG_BORDERC = 10;

  typedef logic [CW-1:0] cnt_t;

  typedef struct packed {
    cnt_t total;
    cnt_t sync_end;
    cnt_t blank_end;
    cnt_t blank_start;
    cnt_t lead_border;
    cnt_t trail_border;
  } axis_t;

  typedef struct packed {
    axis_t h;
    axis_t v;
  } timing_t;

  typedef enum logic [1:0] {
    SEL_ZERO,
    SEL_BLANKC,
    SEL_BORDER,
    SEL_DATA
  } pix_sel_e;

  function automatic logic is_blank(cnt_t p, axis_t a);
    return (p < a.blank_end) || (p >= a.blank_start);
  endfunction
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int AW  = 4,
  parameter int DW  = 32,
  parameter int PXW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  input  logic           frame_wrap,
  output logic           run_en,
  output logic           force_blank,
  output logic           hs_neg,
  output logic           vs_neg,
  output logic [PXW-1:0] blank_color,
  output logic [PXW-1:0] border_color,
  output timing_t        act_tm,
  output logic           timing_bad
);
  localparam int HI = DW / 2;
  localparam int EW = CW + 2;

  timing_t stg_tm;
  cnt_t    lo_f;
  cnt_t    hi_f;
  logic    load_en;

  assign lo_f = cfg_wdata[CW-1:0];
  assign hi_f = cfg_wdata[HI+CW-1:HI];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_tm       <= '0;
      run_en       <= 1'b0;
      force_blank  <= 1'b0;
      hs_neg       <= 1'b0;
      vs_neg       <= 1'b0;
      blank_color  <= '0;
      border_color <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        AW'(REG_CTRL): begin
          run_en      <= cfg_wdata[0];
          force_blank <= cfg_wdata[1];
          hs_neg      <= cfg_wdata[2];
          vs_neg      <= cfg_wdata[3];
        end
        AW'(REG_HTOT):    stg_tm.h.total    <= lo_f;
        AW'(REG_VTOT):    stg_tm.v.total    <= lo_f;
        AW'(REG_HSYNC):   stg_tm.h.sync_end <= lo_f;
        AW'(REG_VSYNC):   stg_tm.v.sync_end <= lo_f;
        AW'(REG_HBLANK): begin
          stg_tm.h.blank_end   <= lo_f;
          stg_tm.h.blank_start <= hi_f;
        end
        AW'(REG_VBLANK): begin
          stg_tm.v.blank_end   <= lo_f;
          stg_tm.v.blank_start <= hi_f;
        end
        AW'(REG_HBORDER): begin
          stg_tm.h.lead_border  <= lo_f;
          stg_tm.h.trail_border <= hi_f;
        end
        AW'(REG_VBORDER): begin
          stg_tm.v.lead_border  <= lo_f;
          stg_tm.v.trail_border <= hi_f;
        end
        AW'(REG_BLANKC):  blank_color  <= cfg_wdata[PXW-1:0];
        AW'(REG_BORDERC): border_color <= cfg_wdata[PXW-1:0];
        default: ;
      endcase
    end
  end

  // Horizontal limits on the staged set
  logic signed [EW-1:0] h_len, fp_len, bp_len, blk_len;
  assign h_len   = $signed(EW'(stg_tm.h.total) + EW'(1));
  assign fp_len  = h_len - $signed(EW'(stg_tm.h.blank_start));
  assign bp_len  = $signed(EW'(stg_tm.h.blank_end)) - $signed(EW'(stg_tm.h.sync_end));
  assign blk_len = fp_len + $signed(EW'(stg_tm.h.blank_end));

  assign timing_bad = (blk_len < $signed(EW'(MIN_HBLANK))) ||
                      (fp_len  < $signed(EW'(MIN_PORCH)))  ||
                      (bp_len  < $signed(EW'(MIN_PORCH)));

  assign load_en = (!run_en || frame_wrap) && !timing_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       act_tm <= '0;
    else if (load_en) act_tm <= stg_tm;
  end
endmodule

// File: rtl/rtg_counter.sv
module rtg_counter
  import rtg_pkg::*;
#(
  parameter int FCW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_en,
  input  timing_t        act_tm,
  output cnt_t           pos_h,
  output cnt_t           pos_v,
  output logic [FCW-1:0] frame_cnt,
  output logic           frame_wrap
);
  logic h_last, v_last, vb_entry;
  cnt_t h_nxt, v_nxt;

  assign h_last = (pos_h == act_tm.h.total);
  assign v_last = (pos_v == act_tm.v.total);

  always_comb begin
    h_nxt = h_last ? '0 : pos_h + 1'b1;
    v_nxt = pos_v;
    if (h_last) v_nxt = v_last ? '0 : pos_v + 1'b1;
  end

  assign frame_wrap = run_en && h_last && v_last;
  assign vb_entry   = run_en && !is_blank(pos_v, act_tm.v) && is_blank(v_nxt, act_tm.v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_h     <= '0;
      pos_v     <= '0;
      frame_cnt <= '0;
    end else if (run_en) begin
      pos_h <= h_nxt;
      pos_v <= v_nxt;
      if (vb_entry) frame_cnt <= frame_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rtg_axis_dec.sv
module rtg_axis_dec
  import rtg_pkg::*;
(
  input  cnt_t  pos,
  input  axis_t cfg,
  output logic  blank,
  output logic  sync_on,
  output logic  area
);
  cnt_t area_lo, area_hi;
  assign area_lo = cfg.blank_end + cfg.lead_border;
  assign area_hi = cfg.blank_start - cfg.trail_border;
  assign blank   = is_blank(pos, cfg);
  assign sync_on = pos < cfg.sync_end;
  assign area    = (pos >= area_lo) && (pos < area_hi);
endmodule

// File: rtl/rtg_pixmux.sv
module rtg_pixmux
  import rtg_pkg::*;
#(
  parameter int PXW = 24
) (
  input  logic           force_blank,
  input  logic           in_blank,
  input  logic           in_area,
  input  logic           pix_valid,
  input  logic [PXW-1:0] pix_data,
  input  logic [PXW-1:0] blank_color,
  input  logic [PXW-1:0] border_color,
  output logic [PXW-1:0] pix_out
);
  pix_sel_e sel;

  always_comb begin
    if (force_blank)    sel = SEL_BLANKC;
    else if (in_blank)  sel = SEL_ZERO;
    else if (!in_area)  sel = SEL_BORDER;
    else if (pix_valid) sel = SEL_DATA;
    else                sel = SEL_BLANKC;
  end

  always_comb begin
    unique case (sel)
      SEL_ZERO:   pix_out = '0;
      SEL_BLANKC: pix_out = blank_color;
      SEL_BORDER: pix_out = border_color;
      SEL_DATA:   pix_out = pix_data;
      default:    pix_out = '0;
    endcase
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int AW  = 4,
  parameter int DW  = 32,
  parameter int PXW = 24,
  parameter int FCW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  input  logic           pix_in_valid,
  output logic           pix_in_ready,
  input  logic [PXW-1:0] pix_in_data,
  output logic [PXW-1:0] pix_out,
  output logic           de,
  output logic           hsync,
  output logic           vsync,
  output logic           hblank,
  output logic           vblank,
  output logic [CW-1:0]  pos_h,
  output logic [CW-1:0]  pos_v,
  output logic [FCW-1:0] frame_cnt,
  output logic           timing_bad
);
  timing_t        act_tm;
  logic           run_en, force_blank, hs_neg, vs_neg, frame_wrap;
  logic [PXW-1:0] blank_color, border_color;
  logic [1:0]     ax_blank, ax_sync, ax_area;
  cnt_t           ax_pos [2];
  axis_t          ax_cfg [2];

  rtg_regs #(.AW(AW), .DW(DW), .PXW(PXW)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .frame_wrap,
    .run_en, .force_blank, .hs_neg, .vs_neg,
    .blank_color, .border_color, .act_tm, .timing_bad
  );

  rtg_counter #(.FCW(FCW)) u_cnt (
    .clk, .rst_n, .run_en, .act_tm,
    .pos_h, .pos_v, .frame_cnt, .frame_wrap
  );

  assign ax_pos[0] = pos_h;
  assign ax_pos[1] = pos_v;
  assign ax_cfg[0] = act_tm.h;
  assign ax_cfg[1] = act_tm.v;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    rtg_axis_dec u_dec (
      .pos(ax_pos[a]), .cfg(ax_cfg[a]),
      .blank(ax_blank[a]), .sync_on(ax_sync[a]), .area(ax_area[a])
    );
  end

  assign hblank       = ax_blank[0];
  assign vblank       = ax_blank[1];
  assign hsync        = ax_sync[0] ^ hs_neg;
  assign vsync        = ax_sync[1] ^ vs_neg;
  assign de           = !hblank && !vblank && (&ax_area);
  assign pix_in_ready = run_en && de;

  rtg_pixmux #(.PXW(PXW)) u_mux (
    .force_blank, .in_blank(hblank || vblank), .in_area(de),
    .pix_valid(pix_in_valid), .pix_data(pix_in_data),
    .blank_color, .border_color, .pix_out
  );
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
  import rtg_pkg::*;
#(
  parameter int PXW = 24,
  parameter int FCW = 24
) (
  input logic           clk,
  input logic           rst_n,
  input logic           run_en,
  input logic           force_blank,
  input timing_t        act_tm,
  input logic [CW-1:0]  pos_h,
  input logic [CW-1:0]  pos_v,
  input logic [FCW-1:0] frame_cnt,
  input logic           pix_in_ready,
  input logic           de,
  input logic [PXW-1:0] pix_out,
  input logic [PXW-1:0] blank_color,
  input logic           timing_bad
);
  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(pos_h) && $stable(pos_v) && $stable(frame_cnt)); // R7

  AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && (pos_h != act_tm.h.total) |=> pos_h == $past(pos_h) + 1'b1); // R1

  AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && (pos_h == act_tm.h.total) |=> pos_h == '0); // R1

  AST_READY_IN_AREA: assert property (@(posedge clk) disable iff (!rst_n)
    pix_in_ready |-> de && run_en); // R4

  AST_FORCED_COLOR: assert property (@(posedge clk) disable iff (!rst_n)
    force_blank |-> pix_out == blank_color); // R6

  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_cnt) |-> frame_cnt == $past(frame_cnt) + 1'b1); // R8

  AST_BAD_NOT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    timing_bad |=> $stable(act_tm)); // R10

  AST_MIDFRAME_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && !((pos_h == act_tm.h.total) && (pos_v == act_tm.v.total)) |=> $stable(act_tm)); // R9
endmodule

bind raster_timing_gen rtg_checker #(.PXW(PXW), .FCW(FCW)) u_rtg_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .force_blank(force_blank),
  .act_tm(act_tm), .pos_h(pos_h), .pos_v(pos_v), .frame_cnt(frame_cnt),
  .pix_in_ready(pix_in_ready), .de(de), .pix_out(pix_out),
  .blank_color(blank_color), .timing_bad(timing_bad)
);

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;
  localparam int AW = 4, DW = 32, PXW = 24, FCW = 4, CW = 12;
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic pix_in_valid = 1'b0;
  logic [PXW-1:0] pix_in_data = '0;
  logic pix_in_ready, de, hsync, vsync, hblank, vblank, timing_bad;
  logic [PXW-1:0] pix_out;
  logic [CW-1:0] pos_h, pos_v;
  logic [FCW-1:0] frame_cnt;

  always #4 clk = ~clk;

  raster_timing_gen #(.AW(AW), .DW(DW), .PXW(PXW), .FCW(FCW)) dut (.*);

  int n_cmp = 0, n_bad = 0, cyc = 0, vmode = 0;
  string phase = "R1";

  // Reference state: index 0..5 horizontal, 6..11 vertical
  // (total, sync-end, blank-end, blank-start, lead border, trail border)
  int st [12];
  int ac [12];
  int m_run = 0, m_fb = 0, m_hn = 0, m_vn = 0, m_bc = 0, m_oc = 0;
  int mh = 0, mv = 0, mf = 0;

  initial for (int i = 0; i < 12; i++) begin st[i] = 0; ac[i] = 0; end

  function automatic bit st_bad();
    int fp = st[0] + 1 - st[3];
    int bp = st[2] - st[1];
    return (fp + st[2] < 56) || (fp < 4) || (bp < 4);
  endfunction

  function automatic bit blank_at(int p, int base);
    return (p < ac[base+2]) || (p >= ac[base+3]);
  endfunction

  function automatic bit area_at(int p, int base);
    return (p >= ac[base+2] + ac[base+4]) && (p < ac[base+3] - ac[base+5]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 12; i++) begin st[i] = 0; ac[i] = 0; end
      m_run = 0; m_fb = 0; m_hn = 0; m_vn = 0; m_bc = 0; m_oc = 0;
      mh = 0; mv = 0; mf = 0;
    end else begin
      int lo, hi, nh, nv;
      bit wrap, ld;
      wrap = (m_run != 0) && (mh == ac[0]) && (mv == ac[6]);
      ld = ((m_run == 0) || wrap) && !st_bad();
      if (m_run != 0) begin
        nh = (mh == ac[0]) ? 0 : mh + 1;
        nv = mv;
        if (mh == ac[0]) nv = (mv == ac[6]) ? 0 : mv + 1;
        if (!blank_at(mv, 6) && blank_at(nv, 6)) mf = (mf + 1) % (1 << FCW);
        mh = nh; mv = nv;
      end
      if (ld) for (int i = 0; i < 12; i++) ac[i] = st[i];
      if (cfg_we) begin
        lo = int'(cfg_wdata) & 'hFFF;
        hi = int'(cfg_wdata >> 16) & 'hFFF;
        case (int'(cfg_addr))
          0: begin m_run = cfg_wdata[0]; m_fb = cfg_wdata[1];
                   m_hn = cfg_wdata[2]; m_vn = cfg_wdata[3]; end
          1: st[0] = lo;
          2: st[6] = lo;
          3: st[1] = lo;
          4: st[7] = lo;
          5: begin st[2] = lo; st[3] = hi; end
          6: begin st[8] = lo; st[9] = hi; end
          7: begin st[4] = lo; st[5] = hi; end
          8: begin st[10] = lo; st[11] = hi; end
          9: m_bc = int'(cfg_wdata) & 'hFFFFFF;
          10: m_oc = int'(cfg_wdata) & 'hFFFFFF;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string req, string sig, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (%s) %s at cycle %0d: actual %0h expected %0h",
               req, phase, sig, cyc, act, exp);
    end
  endtask

  task automatic compare_all();
    bit hb, vb, e;
    int px;
    hb = blank_at(mh, 0);
    vb = blank_at(mv, 6);
    e  = !hb && !vb && area_at(mh, 0) && area_at(mv, 6);
    if (m_fb != 0)          px = m_bc;
    else if (hb || vb)      px = 0;
    else if (!e)            px = m_oc;
    else if (pix_in_valid)  px = int'(pix_in_data);
    else                    px = m_bc;
    chk("R1", "pos_h", int'(pos_h), mh);
    chk("R1", "pos_v", int'(pos_v), mv);
    chk("R2", "hsync", int'(hsync), int'((mh < ac[1]) ^ (m_hn != 0)));
    chk("R2", "vsync", int'(vsync), int'((mv < ac[7]) ^ (m_vn != 0)));
    chk("R3", "hblank", int'(hblank), int'(hb));
    chk("R3", "vblank", int'(vblank), int'(vb));
    chk("R4", "de", int'(de), int'(e));
    chk("R4", "pix_in_ready", int'(pix_in_ready), int'(e && (m_run != 0)));
    chk((m_fb != 0) ? "R6" : "R5", "pix_out", int'(pix_out), px);
    chk("R8", "frame_cnt", int'(frame_cnt), mf);
    chk("R10", "timing_bad", int'(timing_bad), int'(st_bad()));
  endtask

  task automatic step(bit we, int addr, int data);
    @(negedge clk);
    cyc++;
    cfg_we      = we;
    cfg_addr    = AW'(addr);
    cfg_wdata   = DW'(data);
    pix_in_valid = (vmode == 0) ? 1'b1 : ((cyc % 3) != 0);
    pix_in_data  = PXW'(cyc * 7919);
    #1;
    compare_all();
  endtask

  task automatic wr(int addr, int data); step(1'b1, addr, data); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) step(1'b0, 0, 0); endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(WATCHDOG * 8);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    summary();
    $finish;
  end

  initial begin
    int hold_h, hold_v, hold_f;
    phase = "R1 reset";
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // Program a 120 x 10 raster while stopped
    phase = "R11 program";
    wr(1, 119);
    wr(3, 8);
    wr(5, (64 << 16) | 30);
    wr(7, (2 << 16) | 2);
    wr(2, 9);
    wr(4, 1);
    wr(6, (9 << 16) | 3);
    wr(8, (1 << 16) | 1);
    wr(9, 'h123456);
    wr(10, 'h00A0F0);
    idle(3);

    phase = "R7 start";
    wr(0, 1);
    idle(2500);

    phase = "R5 gappy input";
    vmode = 1;
    idle(1300);
    vmode = 0;

    phase = "R6 forced blank";
    wr(0, 3);
    idle(400);
    wr(0, 1);

    phase = "R2 negative sync";
    wr(0, 'hD);
    idle(1300);

    phase = "R9 mid-frame change";
    wr(5, (64 << 16) | 34);
    idle(1500);

    phase = "R10 short blank rejected";
    wr(1, 70);
    idle(1300);
    wr(1, 119);
    idle(1300);

    phase = "R7 stopped";
    wr(0, 0);
    idle(2);
    hold_h = int'(pos_h); hold_v = int'(pos_v); hold_f = int'(frame_cnt);
    idle(200);
    chk("R7", "held pos_h", int'(pos_h), hold_h);
    chk("R7", "held pos_v", int'(pos_v), hold_v);
    chk("R7", "held frame_cnt", int'(frame_cnt), hold_f);

    phase = "R10 porch limits";
    wr(3, 32);
    idle(4);
    wr(3, 8);
    wr(5, (117 << 16) | 34);
    idle(4);
    wr(5, (64 << 16) | 30);
    idle(4);

    phase = "R8 frame wrap";
    wr(0, 1);
    idle(21000);

    summary();
    $finish;
  end
endmodule